// File: doc/BRIEF.md
# Field Memory Read-Port Address Controller

This block sequences the read side of a line-organised field memory. A line is chosen either by shifting a 9-bit line number in serially, one bit per clock, or by a single-cycle reset command. The commands return to word 0 of the current line, jump to line 0, step to the next line, or jump to the last line number that was shifted in. After any new line is entered, one clock is spent fetching that line from the array. Serial reads then walk through the words of the line.

Two enables shape the stream. The read enable gates the word pointer: when it is low, the same word comes out again. The output enable gates only the drive flag: when it is low, the output is blanked but the pointer keeps moving. The pointer parks on the last word of a line. The array is modelled as a synchronous word store that the block addresses with `arr_line` and `arr_word`. Data reaches `dout` one clock after the cycle in which it was addressed. The tri-state output is represented by a data bus plus a drive flag.

Top module: `fm_rd_port`

## Requirements
- R1: While `rd_rst`=0 and `rd_ade`=1, one bit of `rd_sad` is shifted in per clock, most significant bit first. On the clock that takes the 9th bit, the line becomes the shifted value, the word becomes 0 and that value is stored for jumps. Dropping `rd_ade` early discards the partial address. Nothing is driven while `rd_ade`=1.
- R2: A clock with `rd_rst`=1, `rd_inc`=0, `rd_ade`=0 keeps the line and sets the word to 0.
- R3: A clock with `rd_rst`=1, `rd_inc`=0, `rd_ade`=1 sets the line and the word to 0. The stored jump address is left unchanged.
- R4: A clock with `rd_rst`=1, `rd_inc`=1, `rd_ade`=0 moves to the next line at word 0. The line after LINES-1 is line 0.
- R5: A clock with `rd_rst`=1, `rd_inc`=1, `rd_ade`=1 moves to the stored line address at word 0.
- R6: After any reset command or completed address load, `line_fetch` is 1 for the following cycle. That cycle reads no word and drives nothing.
- R7: With both `rd_en` and `out_en` at 1 in a read cycle, the word advances by one. The addressed word appears on `dout` with `dout_drv`=1 after that same clock.
- R8: With `rd_en`=1 and `out_en`=0, the word advances, `dout_drv` is 0 and `dout` is 0.
- R9: With `rd_en`=0 and `out_en`=1, the word holds and the same word is driven again.
- R10: With both enables at 0, the word holds and nothing is driven.
- R11: The word never passes WORDS-1. A read at the last word leaves it there.
- R12: After reset, line and word are 0, `line_fetch` and `dout_drv` are 0, and no read takes place until a line has been entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_rst | input | 1 | Selects a reset command this cycle |
| rd_inc | input | 1 | Command select bit (upper) |
| rd_ade | input | 1 | Serial address enable; command select bit (lower) |
| rd_sad | input | 1 | Serial line address bit |
| rd_en | input | 1 | Read enable: advances the word pointer |
| out_en | input | 1 | Output enable: drive flag for the next output |
| arr_line | output | AW | Line address to the array |
| arr_word | output | WW | Word address to the array |
| arr_rd | output | 1 | Array word read in this cycle |
| arr_rdata | input | DW | Array read data, registered one clock after `arr_rd` |
| line_fetch | output | 1 | Line fetch cycle in progress |
| dout | output | DW | Read data, 0 when not driven |
| dout_drv | output | 1 | Output drive flag |

## Verification
On every cycle the assertions check that the word stays in range and that it holds whenever `rd_en` is low. They also check the line and word results of the hold and clear commands, that the fetch cycle never drives and lasts one clock, that the drive flag follows `out_en`, and that the stored jump address moves only on a completed load. The bench scenarios are the only way to show the serial bit order and the completion point of a load. They also cover the jump to a previously stored line after a clear, the wrap of the line increment, the parking at the last word, and the correct data arriving one clock after it was addressed.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
    // Command select while rd_rst is high: {rd_inc, rd_ade}
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'b00,
        CMD_CLEAR = 2'b01,
        CMD_NEXT  = 2'b10,
        CMD_JUMP  = 2'b11
    } rst_cmd_e;
endpackage

// File: rtl/fmr_addr_loader.sv
module fmr_addr_loader #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          sbit,
    output logic          load_done,
    output logic [AW-1:0] load_addr,
    output logic [AW-1:0] stored_addr
);
    localparam int CW = $clog2(AW);
    localparam logic [CW-1:0] LAST_BIT = CW'(AW - 1);

    typedef struct packed {
        logic [AW-1:0] shreg;
        logic [CW-1:0] cnt;
        logic [AW-1:0] stored;
    } ld_state_t;

    ld_state_t st_d, st_q;

    assign load_done   = load_en && (st_q.cnt == LAST_BIT);
    assign load_addr   = {st_q.shreg[AW-2:0], sbit};
    assign stored_addr = st_q.stored;

    always_comb begin
        st_d = st_q;
        if (!load_en) begin
            st_d.cnt = '0;
        end else begin
            st_d.shreg = load_addr;
            if (load_done) begin
                st_d.cnt    = '0;
                st_d.stored = load_addr;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_BIT);
    // R3
    stored_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(stored_addr));
endmodule

// File: rtl/fmr_read_pointer.sv
module fmr_read_pointer
    import fmr_pkg::*;
#(
    parameter int WORDS = 960,
    parameter int LINES = 290,
    parameter int AW    = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rrst,
    input  logic                     inc,
    input  logic                     ade,
    input  logic                     load_done,
    input  logic [AW-1:0]            load_addr,
    input  logic [AW-1:0]            stored_addr,
    input  logic                     re,
    input  logic                     oe,
    output logic [AW-1:0]            line,
    output logic [$clog2(WORDS)-1:0] word,
    output logic                     fetch,
    output logic                     rd,
    output logic                     drv
);
    localparam int WW = $clog2(WORDS);
    localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);
    localparam logic [AW-1:0] LAST_LINE = AW'(LINES - 1);

    typedef struct packed {
        logic [AW-1:0] line;
        logic [WW-1:0] word;
        logic          fetch;
        logic          ready;
        logic          drv;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    rst_cmd_e   cmd;

    assign cmd   = rst_cmd_e'({inc, ade});
    assign rd    = st_q.ready && !rrst && !ade && !st_q.fetch;
    assign line  = st_q.line;
    assign word  = st_q.word;
    assign fetch = st_q.fetch;
    assign drv   = st_q.drv;

    always_comb begin
        st_d     = st_q;
        st_d.drv = rd && oe;
        if (rrst) begin
            unique case (cmd)
                CMD_HOLD:  st_d.line = st_q.line;
                CMD_CLEAR: st_d.line = '0;
                CMD_NEXT:  st_d.line = (st_q.line == LAST_LINE) ? '0 : st_q.line + 1'b1;
                CMD_JUMP:  st_d.line = stored_addr;
                default:   st_d.line = st_q.line;
            endcase
            st_d.word  = '0;
            st_d.fetch = 1'b1;
            st_d.ready = 1'b0;
        end else if (load_done) begin
            st_d.line  = load_addr;
            st_d.word  = '0;
            st_d.fetch = 1'b1;
            st_d.ready = 1'b0;
        end else if (!ade) begin
            if (st_q.fetch) begin
                st_d.fetch = 1'b0;
                st_d.ready = 1'b1;
            end else if (rd && re && (st_q.word != LAST_WORD)) begin
                st_d.word = st_q.word + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    word_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word <= LAST_WORD);
    // R9
    word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rrst && !ade && !re) |=> $stable(word));
    // R2
    hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rrst && !inc && !ade) |=> ($stable(line) && word == '0));
    // R3
    clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rrst && !inc && ade) |=> (line == '0 && word == '0));
    // R6
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !rrst && !ade) |=> (!fetch && !drv));
    // R10
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> !drv);
endmodule

// File: rtl/fm_rd_port.sv
module fm_rd_port #(
    parameter int WORDS = 960,
    parameter int LINES = 290,
    parameter int AW    = 9,
    parameter int DW    = 12,
    localparam int WW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_rst,
    input  logic          rd_inc,
    input  logic          rd_ade,
    input  logic          rd_sad,
    input  logic          rd_en,
    input  logic          out_en,
    output logic [AW-1:0] arr_line,
    output logic [WW-1:0] arr_word,
    output logic          arr_rd,
    input  logic [DW-1:0] arr_rdata,
    output logic          line_fetch,
    output logic [DW-1:0] dout,
    output logic          dout_drv
);
    logic          load_done;
    logic [AW-1:0] load_addr;
    logic [AW-1:0] stored_addr;

    fmr_addr_loader #(.AW(AW)) i_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (rd_ade && !rd_rst),
        .sbit        (rd_sad),
        .load_done   (load_done),
        .load_addr   (load_addr),
        .stored_addr (stored_addr)
    );

    fmr_read_pointer #(.WORDS(WORDS), .LINES(LINES), .AW(AW)) i_pointer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rrst        (rd_rst),
        .inc         (rd_inc),
        .ade         (rd_ade),
        .load_done   (load_done),
        .load_addr   (load_addr),
        .stored_addr (stored_addr),
        .re          (rd_en),
        .oe          (out_en),
        .line        (arr_line),
        .word        (arr_word),
        .fetch       (line_fetch),
        .rd          (arr_rd),
        .drv         (dout_drv)
    );

    assign dout = dout_drv ? arr_rdata : '0;

    // R7
    drive_follows_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_drv |-> $past(out_en));
    // R1
    no_read_while_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ade |-> !arr_rd);
endmodule

// File: tb/test_fm_rd_port.sv
module test_fm_rd_port;
    localparam int WORDS = 24;
    localparam int LINES = 10;
    localparam int AW    = 9;
    localparam int DW    = 12;
    localparam int WW    = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_rst = 0, rd_inc = 0, rd_ade = 0, rd_sad = 0, rd_en = 0, out_en = 0;
    logic [AW-1:0] arr_line;
    logic [WW-1:0] arr_word;
    logic          arr_rd, line_fetch, dout_drv;
    logic [DW-1:0] arr_rdata = '0;
    logic [DW-1:0] dout;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference state
    int m_line = 0, m_word = 0, m_addr = 0, m_sh = 0, m_cnt = 0;
    bit m_fetch = 0, m_ready = 0;

    always #2 clk = ~clk;

    fm_rd_port #(.WORDS(WORDS), .LINES(LINES), .AW(AW), .DW(DW)) i_fm_rd_port (
        .clk(clk), .rst_n(rst_n), .rd_rst(rd_rst), .rd_inc(rd_inc), .rd_ade(rd_ade),
        .rd_sad(rd_sad), .rd_en(rd_en), .out_en(out_en), .arr_line(arr_line),
        .arr_word(arr_word), .arr_rd(arr_rd), .arr_rdata(arr_rdata),
        .line_fetch(line_fetch), .dout(dout), .dout_drv(dout_drv)
    );

    function automatic logic [DW-1:0] pattern(int l, int w);
        return DW'((l * 113 + w * 29 + 7) ^ (l << 6));
    endfunction

    // synchronous array model
    always_ff @(posedge clk) if (arr_rd) arr_rdata <= pattern(int'(arr_line), int'(arr_word));

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit rs, bit inc, bit ade, bit sad, bit re, bit oe, string tag);
        bit rd;
        int e_drv, e_dout;
        @(negedge clk);
        rd_rst = rs; rd_inc = inc; rd_ade = ade; rd_sad = sad; rd_en = re; out_en = oe;
        rd     = m_ready && !rs && !ade && !m_fetch;
        e_drv  = (rd && oe) ? 1 : 0;
        e_dout = e_drv ? int'(pattern(m_line, m_word)) : 0;
        if (rs) begin
            case ({inc, ade})
                2'b00: m_line = m_line;
                2'b01: m_line = 0;
                2'b10: m_line = (m_line == LINES - 1) ? 0 : m_line + 1;
                default: m_line = m_addr;
            endcase
            m_word = 0; m_fetch = 1; m_ready = 0; m_cnt = 0;
        end else if (ade) begin
            m_sh = ((m_sh << 1) | int'(sad)) & ((1 << AW) - 1);
            if (m_cnt == AW - 1) begin
                m_addr = m_sh; m_line = m_sh; m_word = 0;
                m_fetch = 1; m_ready = 0; m_cnt = 0;
            end else m_cnt++;
        end else begin
            m_cnt = 0;
            if (m_fetch) begin m_fetch = 0; m_ready = 1; end
            else if (rd && re && m_word != WORDS - 1) m_word++;
        end
        @(posedge clk); #1;
        chk(tag, "line", int'(arr_line), m_line);
        chk(tag, "word", int'(arr_word), m_word);
        chk(tag, "fetch", int'(line_fetch), int'(m_fetch));
        chk(tag, "drv", int'(dout_drv), e_drv);
        chk(tag, "dout", int'(dout), e_dout);
    endtask

    task automatic load(int a, string tag);
        for (int i = AW - 1; i >= 0; i--) step(0, 0, 1, a[i], 1, 1, tag);
    endtask

    initial begin
        void'($urandom(32'h1f3a));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R12 reset state and no read before a line is entered
        chk("R12", "line", int'(arr_line), 0);
        chk("R12", "word", int'(arr_word), 0);
        chk("R12", "drv", int'(dout_drv), 0);
        step(0, 0, 0, 0, 1, 1, "R12");
        step(0, 0, 0, 0, 1, 1, "R12");
        // R1 serial load of line 5, R6 fetch cycle
        load(5, "R1");
        chk("R1", "loaded line", int'(arr_line), 5);
        step(0, 0, 0, 0, 1, 1, "R6");
        // R7 streaming
        repeat (4) step(0, 0, 0, 0, 1, 1, "R7");
        step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 0, 0, "R10");
        // R11 park on last word
        repeat (WORDS + 3) step(0, 0, 0, 0, 1, 1, "R11");
        chk("R11", "parked word", int'(arr_word), WORDS - 1);
        // R2 hold
        step(1, 0, 0, 0, 1, 1, "R2");
        chk("R2", "held line", int'(arr_line), 5);
        step(0, 0, 0, 0, 1, 1, "R6");
        repeat (3) step(0, 0, 0, 0, 1, 1, "R7");
        // R3 clear then R5 jump back to stored line 5
        step(1, 0, 1, 0, 1, 1, "R3");
        chk("R3", "cleared line", int'(arr_line), 0);
        step(0, 0, 0, 0, 1, 1, "R6");
        step(0, 0, 0, 0, 1, 1, "R7");
        step(1, 1, 1, 0, 1, 1, "R5");
        chk("R5", "jump line", int'(arr_line), 5);
        step(0, 0, 0, 0, 1, 1, "R6");
        // R4 increment wrap from LINES-1
        load(LINES - 1, "R1");
        step(0, 0, 0, 0, 1, 1, "R6");
        step(1, 1, 0, 0, 1, 1, "R4");
        chk("R4", "wrapped line", int'(arr_line), 0);
        step(1, 1, 0, 0, 1, 1, "R4");
        // R1 aborted partial load leaves line alone
        step(0, 0, 0, 0, 1, 1, "R6");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 1, "R1");
        step(0, 0, 0, 0, 1, 1, "R1");
        chk("R1", "after abort", int'(arr_line), 1);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            bit re, oe;
            r  = int'($urandom % 100);
            re = 1'($urandom); oe = 1'($urandom);
            if (r < 4) step(1, 1'($urandom), 1'($urandom), 0, re, oe, "R2");
            else if (r < 7) load(int'($urandom % LINES), "R1");
            else if (re && oe) step(0, 0, 0, 1'($urandom), 1, 1, "R7");
            else if (re) step(0, 0, 0, 1'($urandom), 1, 0, "R8");
            else if (oe) step(0, 0, 0, 1'($urandom), 0, 1, "R9");
            else step(0, 0, 0, 1'($urandom), 0, 0, "R10");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule